// File: doc/BRIEF.md
# Three-Level Packed Return Stack

This block keeps the subroutine return state of a small 4-bit controller whose program address is built from a PC, a 4-bit page and a 2-bit chapter. Each of the page and chapter has an active address and a buffer that is loaded ahead of a jump. The block takes the current values of all five, a jump target and one strobe per cycle (call, branch or return) qualified by the status flag. It returns the values those five registers must take next. The owner of those registers writes them back on the same clock edge.

The saved state sits in three packed shift registers, one per field. A call shifts each one left by the field width and inserts the current value. A return reads the low field and shifts right. A 3-bit thermometer mask records how many levels hold data. A return on an empty mask does nothing. A fourth nested call pushes the oldest entry off the top end.

Top module: `ret_stack3`

## Requirements
- R1: A taken call (call strobe with status 1) adds one level to the occupancy mask. Up to three levels are kept, and each later return then restores one of them.
- R2: On a taken call the PC output is the target. The page output takes the page buffer input, and the chapter output takes the chapter buffer input. Both buffer outputs equal their inputs.
- R3: A call with status 0 saves nothing. The page buffer output takes the page input, and the chapter buffer output takes the chapter input. The PC, page and chapter outputs equal their inputs.
- R4: A return with at least one level occupied restores the most recently saved PC to the PC output. The saved page goes to both the page output and the page buffer output. The saved chapter goes to both the chapter output and the chapter buffer output. Successive returns unwind in last-in, first-out order.
- R5: A return with no level occupied leaves every output equal to its input and changes no saved state.
- R6: A taken branch sets the PC output to the target, the page output to the page buffer input and the chapter output to the chapter buffer input, whatever the stack depth. It leaves the saved state untouched.
- R7: A branch with status 0 leaves every output equal to its input.
- R8: After four taken calls without a return, the next three returns restore the fourth, third and second saved frames, and a further return has no effect.
- R9: After reset no level is occupied, so a first return has no effect.
- R10: With no strobe active, every output equals its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the stack |
| status_i | input | 1 | Condition flag qualifying call and branch |
| call_i | input | 1 | Call strobe |
| branch_i | input | 1 | Branch strobe |
| return_i | input | 1 | Return strobe |
| target_i | input | PC_W | Jump target PC |
| pc_i | input | PC_W | Current PC |
| page_i | input | PAGE_W | Current page address |
| page_buf_i | input | PAGE_W | Current page buffer |
| chap_i | input | CHAP_W | Current chapter address |
| chap_buf_i | input | CHAP_W | Current chapter buffer |
| pc_o | output | PC_W | Next PC |
| page_o | output | PAGE_W | Next page address |
| page_buf_o | output | PAGE_W | Next page buffer |
| chap_o | output | CHAP_W | Next chapter address |
| chap_buf_o | output | CHAP_W | Next chapter buffer |

## Verification
The assertions take for granted that at most one of the call, branch and return strobes is high in any cycle, because the block resolves a clash by fixed priority and does not define it as behaviour. The stimulus keeps to this rule: each step drives exactly one strobe or none. Each step also feeds the block's previous outputs back as its next inputs, as the surrounding register file would. The bench only overrides the PC and the buffers where a program would load them.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } stack_act_e;

endpackage

// File: rtl/ret_stack_level.sv
module ret_stack_level
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stack_act_e       act_i,
    output logic [DEPTH-1:0] mask_o
);

    logic [DEPTH-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        case (act_i)
            ACT_PUSH: mask_d = {mask_q[DEPTH-2:0], 1'b1};
            ACT_POP:  mask_d = {1'b0, mask_q[DEPTH-1:1]};
            default:  mask_d = mask_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    AST_MASK_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & (mask_q + 1'b1)) == '0); // R1

    AST_PUSH_SETS_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_PUSH |=> mask_q[0]); // R1

endmodule

// File: rtl/ret_stack_lane.sv
module ret_stack_lane
    import ret_stack_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stack_act_e   act_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);

    localparam int SW = W * DEPTH;

    logic [SW-1:0] store_d, store_q;

    always_comb begin
        store_d = store_q;
        case (act_i)
            ACT_PUSH: store_d = {store_q[SW-W-1:0], din_i};
            ACT_POP:  store_d = {{W{1'b0}}, store_q[SW-1:W]};
            default:  store_d = store_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else        store_q <= store_d;
    end

    assign top_o = store_q[W-1:0];

    AST_PUSH_LANDS_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_PUSH |=> top_o == $past(din_i)); // R4

endmodule

// File: rtl/ret_stack3.sv
module ret_stack3
    import ret_stack_pkg::*;
#(
    parameter int PC_W   = 6,
    parameter int PAGE_W = 4,
    parameter int CHAP_W = 2,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_i,
    input  logic              call_i,
    input  logic              branch_i,
    input  logic              return_i,
    input  logic [PC_W-1:0]   target_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0] page_buf_i,
    input  logic [CHAP_W-1:0] chap_i,
    input  logic [CHAP_W-1:0] chap_buf_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [PAGE_W-1:0] page_buf_o,
    output logic [CHAP_W-1:0] chap_o,
    output logic [CHAP_W-1:0] chap_buf_o
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] page_buf;
        logic [CHAP_W-1:0] chap;
        logic [CHAP_W-1:0] chap_buf;
    } regs_t;

    stack_act_e        act;
    logic [DEPTH-1:0]  lvl;
    logic [PC_W-1:0]   pc_top;
    logic [PAGE_W-1:0] page_top;
    logic [CHAP_W-1:0] chap_top;
    regs_t             nxt;

    always_comb begin
        act          = ACT_HOLD;
        nxt.pc       = pc_i;
        nxt.page     = page_i;
        nxt.page_buf = page_buf_i;
        nxt.chap     = chap_i;
        nxt.chap_buf = chap_buf_i;
        if (call_i) begin
            if (status_i) begin
                act      = ACT_PUSH;
                nxt.pc   = target_i;
                nxt.page = page_buf_i;
                nxt.chap = chap_buf_i;
            end else begin
                nxt.page_buf = page_i;
                nxt.chap_buf = chap_i;
            end
        end else if (branch_i && status_i) begin
            nxt.pc   = target_i;
            nxt.page = page_buf_i;
            nxt.chap = chap_buf_i;
        end else if (return_i && lvl[0]) begin
            act          = ACT_POP;
            nxt.pc       = pc_top;
            nxt.page     = page_top;
            nxt.page_buf = page_top;
            nxt.chap     = chap_top;
            nxt.chap_buf = chap_top;
        end
    end

    ret_stack_level #(.DEPTH(DEPTH)) i_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act),
        .mask_o (lvl)
    );

    ret_stack_lane #(.W(PC_W), .DEPTH(DEPTH)) i_pc_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .din_i (pc_i),
        .top_o (pc_top)
    );

    ret_stack_lane #(.W(PAGE_W), .DEPTH(DEPTH)) i_page_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .din_i (page_i),
        .top_o (page_top)
    );

    ret_stack_lane #(.W(CHAP_W), .DEPTH(DEPTH)) i_chap_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .din_i (chap_i),
        .top_o (chap_top)
    );

    assign pc_o       = nxt.pc;
    assign page_o     = nxt.page;
    assign page_buf_o = nxt.page_buf;
    assign chap_o     = nxt.chap;
    assign chap_buf_o = nxt.chap_buf;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({call_i, branch_i, return_i})); // R10

    AST_EMPTY_RETURN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        return_i && !call_i && !branch_i && !lvl[0] |=> $stable(lvl)); // R5

    AST_BRANCH_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        branch_i && !call_i |=> $stable(lvl)); // R6

    AST_UNTAKEN_CALL_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        call_i && !status_i |=> $stable(lvl)); // R3

endmodule

// File: tb/test_ret_stack3.sv
`timescale 1ns/1ps
module test_ret_stack3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       status_i = 1'b0, call_i = 1'b0, branch_i = 1'b0, return_i = 1'b0;
    logic [5:0] target_i = '0, pc_i = '0;
    logic [3:0] page_i = '0, page_buf_i = '0;
    logic [1:0] chap_i = '0, chap_buf_i = '0;
    logic [5:0] pc_o;
    logic [3:0] page_o, page_buf_o;
    logic [1:0] chap_o, chap_buf_o;

    always #2 clk = ~clk;

    ret_stack3 i_ret_stack3 (
        .clk(clk), .rst_n(rst_n), .status_i(status_i), .call_i(call_i),
        .branch_i(branch_i), .return_i(return_i), .target_i(target_i),
        .pc_i(pc_i), .page_i(page_i), .page_buf_i(page_buf_i),
        .chap_i(chap_i), .chap_buf_i(chap_buf_i), .pc_o(pc_o),
        .page_o(page_o), .page_buf_o(page_buf_o), .chap_o(chap_o),
        .chap_buf_o(chap_buf_o)
    );

    typedef struct {
        logic [5:0] pc;
        logic [3:0] pg;
        logic [1:0] ch;
    } frame_t;

    typedef struct {
        logic [5:0] pc;
        logic [3:0] pg;
        logic [3:0] pb;
        logic [1:0] ch;
        logic [1:0] cb;
        string      req;
    } exp_t;

    frame_t saved[$];
    exp_t   exp_q[$];
    int     checks = 0;
    int     errors = 0;
    bit     done = 0;

    logic [5:0] cur_pc = 6'h05;
    logic [3:0] cur_pg = 4'h3, cur_pb = 4'h3;
    logic [1:0] cur_ch = 2'd1, cur_cb = 2'd1;

    task automatic step(input logic c, input logic b, input logic r,
                        input logic s, input logic [5:0] tgt, input string req);
        exp_t   e;
        frame_t f;
        @(posedge clk);
        #1;
        call_i = c; branch_i = b; return_i = r; status_i = s; target_i = tgt;
        pc_i = cur_pc; page_i = cur_pg; page_buf_i = cur_pb;
        chap_i = cur_ch; chap_buf_i = cur_cb;
        e.pc = cur_pc; e.pg = cur_pg; e.pb = cur_pb; e.ch = cur_ch; e.cb = cur_cb;
        e.req = req;
        if (c) begin
            if (s) begin
                f.pc = cur_pc; f.pg = cur_pg; f.ch = cur_ch;
                saved.push_back(f);
                if (saved.size() > 3) void'(saved.pop_front());
                e.pc = tgt; e.pg = cur_pb; e.ch = cur_cb;
            end else begin
                e.pb = cur_pg; e.cb = cur_ch;
            end
        end else if (b && s) begin
            e.pc = tgt; e.pg = cur_pb; e.ch = cur_cb;
        end else if (r && saved.size() > 0) begin
            f = saved.pop_back();
            e.pc = f.pc; e.pg = f.pg; e.pb = f.pg; e.ch = f.ch; e.cb = f.ch;
        end
        exp_q.push_back(e);
        cur_pc = e.pc; cur_pg = e.pg; cur_pb = e.pb; cur_ch = e.ch; cur_cb = e.cb;
    endtask

    // monitor: compare at the falling edge, between drive and capture
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (pc_o !== e.pc || page_o !== e.pg || page_buf_o !== e.pb ||
                    chap_o !== e.ch || chap_buf_o !== e.cb) begin
                    errors++;
                    $display("FAIL %s pc %h/%h page %h/%h pbuf %h/%h chap %h/%h cbuf %h/%h (act/exp)",
                             e.req, pc_o, e.pc, page_o, e.pg, page_buf_o, e.pb,
                             chap_o, e.ch, chap_buf_o, e.cb);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 0, 0, 0, 6'h00, "R10");           // idle pass-through
        step(0, 0, 1, 0, 6'h00, "R9");            // first return after reset
        step(0, 1, 0, 0, 6'h2A, "R7");            // untaken branch
        cur_pb = 4'h7; cur_cb = 2'd2;
        step(0, 1, 0, 1, 6'h11, "R6");            // taken branch, empty stack
        cur_pb = 4'h9; cur_cb = 2'd0;
        step(1, 0, 0, 0, 6'h3C, "R3");            // untaken call copies back
        // three nested calls
        cur_pc = 6'h12; cur_pb = 4'hA; cur_cb = 2'd3;
        step(1, 0, 0, 1, 6'h20, "R2");
        cur_pc = 6'h21; cur_pb = 4'hB; cur_cb = 2'd1;
        step(1, 0, 0, 1, 6'h30, "R1");
        cur_pc = 6'h31; cur_pb = 4'hC; cur_cb = 2'd0;
        step(1, 0, 0, 1, 6'h3F, "R1");
        cur_pb = 4'h5; cur_cb = 2'd2;
        step(0, 1, 0, 1, 6'h08, "R6");            // branch at full depth
        step(1, 0, 0, 0, 6'h01, "R3");            // untaken call at full depth
        step(0, 0, 0, 0, 6'h00, "R10");
        step(0, 0, 1, 0, 6'h00, "R4");
        cur_pc = 6'h2B;
        step(0, 0, 1, 0, 6'h00, "R4");
        step(0, 0, 1, 0, 6'h00, "R4");
        cur_pc = 6'h0E; cur_pb = 4'h6;
        step(0, 0, 1, 0, 6'h00, "R5");            // empty return
        // four nested calls: oldest frame discarded
        for (int i = 0; i < 4; i++) begin
            cur_pc = 6'(8 * i + 3); cur_pb = 4'(i + 1); cur_cb = 2'(i);
            step(1, 0, 0, 1, 6'(8 * i + 7), "R8");
        end
        for (int i = 0; i < 4; i++) begin
            cur_pc = 6'(i + 40);
            step(0, 0, 1, 0, 6'h00, "R8");
        end
        step(0, 0, 0, 0, 6'h00, "R10");
        @(posedge clk); #1 call_i = 0; branch_i = 0; return_i = 0;
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule